// File: doc/BRIEF.md
# Memory-Fetched Script Sequencer

This block is a small control engine that takes the place of a processor in a subsystem. It waits, doing nothing, until it sees a one-cycle start pulse. It then reads operation records out of a RAM region through an ordinary 32-bit bus master port and carries them out one at a time. The operations it knows are:

- a register write on the same bus;
- a register read on the same bus;
- a blocking wait on an interrupt line;
- a stop.

Once started, it needs no outside help to run a whole transaction sequence.

Each record takes 16 bytes at `BASE + index*16`. The engine reads only the first three words of a record, one bus read at a time, and never reads the fourth. Those three words are the opcode, the target bus address, and the write data. The engine exposes the following for observation:

- the record index as a program counter;
- a sticky halt flag;
- the last value read;
- a per-operation event strobe that carries the record index and a flag field.

Top module: `script_sequencer`

## Requirements
- R1: After reset `pc` is 0, `halted` is 0 and no bus read or write is issued until `start` is pulsed.
- R2: Record N starts at `BASE + N*16`. It is fetched as three single-cycle reads at byte offsets 0, 4 and 8, and each read waits for `bus_rd_valid` before the next one issues. The word at offset 12 is never read.
- R3: The first record word selects the operation: 0 stops, 1 writes, 2 reads and 3 waits for the interrupt. Any other value stops the engine in the same way as 0.
- R4: A write operation issues exactly one `bus_wr_en` pulse, with the address taken from word 1, the data taken from word 2, and `bus_wr_be` all ones.
- R5: A read operation issues one `bus_rd_en` pulse at the address in word 1. The engine does not advance until `bus_rd_valid` returns, and then `read_value` holds the returned data.
- R6: During an interrupt wait, `pc` holds the wait record's index and no event fires while `irq_in` is low. The first cycle in which `irq_in` is high ends the wait, and the engine goes on to the next record. This also applies when `irq_in` is already high on entry.
- R7: A stop operation sets `halted`. `halted` and `pc` then hold until the next `start`, and that `start` clears `halted` and runs again from record 0.
- R8: A `start` pulse that arrives while the engine is fetching, executing or waiting has no effect on `pc` or on the running sequence.
- R9: Exactly one `ev_valid` pulse fires per executed operation, and `ev_pc` carries that record's index. `ev_flags` has exactly one bit set: value 0x1 for a write or read, 0x2 for leaving an interrupt wait, and 0x4 for a stop.
- R10: `pc` is 8 bits wide. It goes to 0 on reset and on an accepted `start`, and it increments by one after every operation other than a stop.
- R11: A bus read and a bus write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle start pulse |
| irq_in | input | 1 | Interrupt level awaited by wait operations |
| bus_rd_en | output | 1 | Read request pulse |
| bus_rd_addr | output | 32 | Read byte address |
| bus_rd_data | input | 32 | Read response data |
| bus_rd_valid | input | 1 | Read response valid |
| bus_wr_en | output | 1 | Write request pulse |
| bus_wr_addr | output | 32 | Write byte address |
| bus_wr_data | output | 32 | Write data |
| bus_wr_be | output | 4 | Write byte enables |
| pc | output | 8 | Current record index |
| halted | output | 1 | Engine has stopped |
| read_value | output | 32 | Data returned by the last read operation |
| ev_valid | output | 1 | One pulse per executed operation |
| ev_pc | output | 8 | Index of the operation just executed |
| ev_flags | output | 3 | Kind of event: bit 0 bus op, bit 1 wait exit, bit 2 stop |

## Verification
The hardest situation to reach is a long interrupt wait that the bench stretches while it pokes at the engine. In that window `pc` must stay frozen on the wait record and no event may fire. A stray `start` pulse must also be ignored during the wait.

The bench sets this up with a model device that raises the interrupt a programmed delay after the script writes its doorbell register. The bench then samples `pc` and pulses `start` well inside that delay.

A second script enters the wait with the interrupt already high, so the exit happens on the first cycle. That script then runs into an unknown opcode. A third script stretches read latency, which keeps the engine parked in its read-response state.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    OP_HALT  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_WAIT  = 2'd3
  } op_e;

  localparam int FLAG_W   = 3;
  localparam int FLG_BUS  = 0;
  localparam int FLG_WAKE = 1;
  localparam int FLG_STOP = 2;

  // Unrecognised opcode words fall back to a stop.
  function automatic op_e decode_op(input logic [31:0] w);
    case (w)
      32'd1:   return OP_WRITE;
      32'd2:   return OP_READ;
      32'd3:   return OP_WAIT;
      default: return OP_HALT;
    endcase
  endfunction

endpackage

// File: rtl/seq_fetcher.sv
module seq_fetcher #(
  parameter int              ADDR_W      = 32,
  parameter int              DATA_W      = 32,
  parameter int              PC_W        = 8,
  parameter logic [ADDR_W-1:0] BASE      = 32'h0000_0400,
  parameter int              REC_SHIFT   = 4,
  parameter int              FETCH_WORDS = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          go,
  input  logic [PC_W-1:0]               idx,
  output logic                          rd_en,
  output logic [ADDR_W-1:0]             rd_addr,
  input  logic [DATA_W-1:0]             rd_data,
  input  logic                          rd_valid,
  output logic                          done,
  output logic [FETCH_WORDS*DATA_W-1:0] words
);
  localparam int CNT_W = (FETCH_WORDS > 1) ? $clog2(FETCH_WORDS) : 1;
  localparam int STEP  = DATA_W / 8;

  logic             busy;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      done    <= 1'b0;
    end else begin
      rd_en <= 1'b0;
      done  <= 1'b0;
      if (go) begin
        busy    <= 1'b1;
        cnt     <= '0;
        rd_en   <= 1'b1;
        rd_addr <= BASE + (ADDR_W'(idx) << REC_SHIFT);
      end else if (busy && rd_valid) begin
        if (cnt == CNT_W'(FETCH_WORDS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt     <= cnt + 1'b1;
          rd_en   <= 1'b1;
          rd_addr <= rd_addr + ADDR_W'(STEP);
        end
      end
    end
  end

  for (genvar g = 0; g < FETCH_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (busy && rd_valid && cnt == CNT_W'(g))
        word_q <= rd_data;
    end
    assign words[g*DATA_W +: DATA_W] = word_q;
  end

endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PC_W   = 8,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              irq_in,
  input  logic              rec_done,
  input  logic [DATA_W-1:0] op_word,
  input  logic [DATA_W-1:0] tgt_word,
  input  logic [DATA_W-1:0] val_word,
  output logic              fetch_go,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  output logic [PC_W-1:0]   pc,
  output logic              halted,
  output logic [DATA_W-1:0] read_value,
  output logic              ev_valid,
  output logic [PC_W-1:0]   ev_pc,
  output logic [FLAG_W-1:0] ev_flags,
  output logic              waiting
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_READ, S_WAIT, S_STOP} st_e;

  st_e               st;
  op_e               op_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [DATA_W-1:0] val_q;

  assign waiting = (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      op_q       <= OP_HALT;
      tgt_q      <= '0;
      val_q      <= '0;
      pc         <= '0;
      halted     <= 1'b0;
      fetch_go   <= 1'b0;
      rd_en      <= 1'b0;
      rd_addr    <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      wr_be      <= '0;
      read_value <= '0;
      ev_valid   <= 1'b0;
      ev_pc      <= '0;
      ev_flags   <= '0;
    end else begin
      fetch_go <= 1'b0;
      rd_en    <= 1'b0;
      wr_en    <= 1'b0;
      wr_be    <= '0;
      ev_valid <= 1'b0;
      ev_flags <= '0;
      case (st)
        S_IDLE, S_STOP: begin
          if (start) begin
            pc       <= '0;
            halted   <= 1'b0;
            fetch_go <= 1'b1;
            st       <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (rec_done) begin
            op_q  <= decode_op(32'(op_word));
            tgt_q <= ADDR_W'(tgt_word);
            val_q <= val_word;
            st    <= S_EXEC;
          end
        end
        S_EXEC: begin
          case (op_q)
            OP_WRITE: begin
              wr_en             <= 1'b1;
              wr_addr           <= tgt_q;
              wr_data           <= val_q;
              wr_be             <= '1;
              ev_valid          <= 1'b1;
              ev_pc             <= pc;
              ev_flags[FLG_BUS] <= 1'b1;
              pc                <= pc + 1'b1;
              fetch_go          <= 1'b1;
              st                <= S_FETCH;
            end
            OP_READ: begin
              rd_en   <= 1'b1;
              rd_addr <= tgt_q;
              st      <= S_READ;
            end
            OP_WAIT: st <= S_WAIT;
            default: begin
              halted             <= 1'b1;
              ev_valid           <= 1'b1;
              ev_pc              <= pc;
              ev_flags[FLG_STOP] <= 1'b1;
              st                 <= S_STOP;
            end
          endcase
        end
        S_READ: begin
          if (rd_valid) begin
            read_value        <= rd_data;
            ev_valid          <= 1'b1;
            ev_pc             <= pc;
            ev_flags[FLG_BUS] <= 1'b1;
            pc                <= pc + 1'b1;
            fetch_go          <= 1'b1;
            st                <= S_FETCH;
          end
        end
        S_WAIT: begin
          if (irq_in) begin
            ev_valid           <= 1'b1;
            ev_pc              <= pc;
            ev_flags[FLG_WAKE] <= 1'b1;
            pc                 <= pc + 1'b1;
            fetch_go           <= 1'b1;
            st                 <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/script_sequencer.sv
module script_sequencer
  import seq_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                PC_W      = 8,
  parameter logic [ADDR_W-1:0] BASE      = 32'h0000_0400,
  parameter int                REC_SHIFT = 4,
  localparam int               BE_W      = DATA_W / 8,
  localparam int               N_WORDS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              irq_in,
  output logic              bus_rd_en,
  output logic [ADDR_W-1:0] bus_rd_addr,
  input  logic [DATA_W-1:0] bus_rd_data,
  input  logic              bus_rd_valid,
  output logic              bus_wr_en,
  output logic [ADDR_W-1:0] bus_wr_addr,
  output logic [DATA_W-1:0] bus_wr_data,
  output logic [BE_W-1:0]   bus_wr_be,
  output logic [PC_W-1:0]   pc,
  output logic              halted,
  output logic [DATA_W-1:0] read_value,
  output logic              ev_valid,
  output logic [PC_W-1:0]   ev_pc,
  output logic [FLAG_W-1:0] ev_flags
);
  logic                      fetch_go, rec_done, waiting;
  logic [N_WORDS*DATA_W-1:0] rec_words;
  logic                      f_rd_en, c_rd_en;
  logic [ADDR_W-1:0]         f_rd_addr, c_rd_addr;

  seq_fetcher #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W), .BASE(BASE),
    .REC_SHIFT(REC_SHIFT), .FETCH_WORDS(N_WORDS)
  ) u_fetch (
    .clk(clk), .rst(rst), .go(fetch_go), .idx(pc),
    .rd_en(f_rd_en), .rd_addr(f_rd_addr),
    .rd_data(bus_rd_data), .rd_valid(bus_rd_valid),
    .done(rec_done), .words(rec_words)
  );

  seq_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_core (
    .clk(clk), .rst(rst), .start(start), .irq_in(irq_in),
    .rec_done(rec_done),
    .op_word(rec_words[0 +: DATA_W]),
    .tgt_word(rec_words[DATA_W +: DATA_W]),
    .val_word(rec_words[2*DATA_W +: DATA_W]),
    .fetch_go(fetch_go),
    .rd_en(c_rd_en), .rd_addr(c_rd_addr),
    .rd_data(bus_rd_data), .rd_valid(bus_rd_valid),
    .wr_en(bus_wr_en), .wr_addr(bus_wr_addr), .wr_data(bus_wr_data),
    .wr_be(bus_wr_be),
    .pc(pc), .halted(halted), .read_value(read_value),
    .ev_valid(ev_valid), .ev_pc(ev_pc), .ev_flags(ev_flags),
    .waiting(waiting)
  );

  // Fetcher and core never have a read outstanding at the same time.
  assign bus_rd_en   = f_rd_en | c_rd_en;
  assign bus_rd_addr = f_rd_en ? f_rd_addr : c_rd_addr;

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int PC_W = 8,
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            irq_in,
  input logic            waiting,
  input logic            halted,
  input logic [PC_W-1:0] pc,
  input logic            ev_valid,
  input logic [2:0]      ev_flags,
  input logic            bus_rd_en,
  input logic            bus_wr_en,
  input logic [BE_W-1:0] bus_wr_be
);

  a_r4_full_be: assert property (@(posedge clk) disable iff (rst)
    bus_wr_en |-> bus_wr_be == {BE_W{1'b1}});

  a_r6_wait_holds: assert property (@(posedge clk) disable iff (rst)
    waiting && !irq_in |=> $stable(pc) && !ev_valid);

  a_r6_wake_event: assert property (@(posedge clk) disable iff (rst)
    waiting && irq_in |=> ev_valid && ev_flags == 3'b010);

  a_r7_stop_sticky: assert property (@(posedge clk) disable iff (rst)
    halted && !start |=> halted && $stable(pc));

  a_r7_stop_event: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_flags[2] |-> halted);

  a_r9_one_flag: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $countones(ev_flags) == 1);

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd_en && bus_wr_en));

endmodule

bind script_sequencer seq_checker #(.PC_W(PC_W), .BE_W(BE_W)) u_seq_checker (
  .clk(clk), .rst(rst), .start(start), .irq_in(irq_in), .waiting(waiting),
  .halted(halted), .pc(pc), .ev_valid(ev_valid), .ev_flags(ev_flags),
  .bus_rd_en(bus_rd_en), .bus_wr_en(bus_wr_en), .bus_wr_be(bus_wr_be)
);

// File: tb/tb_script_sequencer.sv
`timescale 1ns/1ps
module tb_script_sequencer;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h0000_0400;
  localparam logic [31:0] DEV        = 32'h8000_0000;
  localparam logic [31:0] REG_DATA   = DEV + 32'h0;
  localparam logic [31:0] REG_BELL   = DEV + 32'h4;
  localparam logic [31:0] REG_ACK    = DEV + 32'h8;
  localparam logic [31:0] REG_SPARE  = DEV + 32'hC;

  logic        clk = 1'b0;
  logic        rst, start, irq_in;
  logic        bus_rd_en, bus_rd_valid, bus_wr_en;
  logic [31:0] bus_rd_addr, bus_rd_data, bus_wr_addr, bus_wr_data;
  logic [3:0]  bus_wr_be;
  logic [7:0]  pc, ev_pc;
  logic        halted, ev_valid;
  logic [31:0] read_value;
  logic [2:0]  ev_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  script_sequencer dut (
    .clk(clk), .rst(rst), .start(start), .irq_in(irq_in),
    .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr),
    .bus_rd_data(bus_rd_data), .bus_rd_valid(bus_rd_valid),
    .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr),
    .bus_wr_data(bus_wr_data), .bus_wr_be(bus_wr_be),
    .pc(pc), .halted(halted), .read_value(read_value),
    .ev_valid(ev_valid), .ev_pc(ev_pc), .ev_flags(ev_flags)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [31:0] ram [0:1023];
  logic [31:0] dev_regs [0:15];
  logic [10:0] ev_q [$];   // {pc, flags}
  logic [63:0] wr_q [$];   // {addr, data}
  int rd_lat = 2, rd_cnt = 0, irq_delay = 100, irq_cnt = 0;
  int reserved_reads = 0, bus_activity = 0;
  logic [31:0] rd_addr_q;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_rec(input int slot, input logic [31:0] op, input logic [31:0] tgt,
                         input logic [31:0] val);
    logic [31:0] a;
    a = BASE + 32'(slot) * 16;
    ram[a[11:2]]     = op;
    ram[a[11:2] + 1] = tgt;
    ram[a[11:2] + 2] = val;
    ram[a[11:2] + 3] = 32'hDEAD_BEEF;  // reserved word, must never be fetched
  endtask

  task automatic exp_ev(input logic [7:0] p, input logic [2:0] f);
    ev_q.push_back({p, f});
  endtask

  task automatic exp_wr(input logic [31:0] a, input logic [31:0] d);
    wr_q.push_back({a, d});
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  function automatic logic [31:0] lookup(input logic [31:0] a);
    if (a < 32'h1000) return ram[a[11:2]];
    if (a[31:28] == 4'h8) return dev_regs[a[5:2]];
    return 32'h0;
  endfunction

  // Bus slave model: memory, device registers, interrupt source.
  initial begin
    bus_rd_valid = 1'b0;
    bus_rd_data  = '0;
    forever begin
      @(negedge clk);
      bus_rd_valid = 1'b0;
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin
          bus_rd_valid = 1'b1;
          bus_rd_data  = lookup(rd_addr_q);
        end
      end
      if (irq_cnt > 0) begin
        irq_cnt--;
        if (irq_cnt == 0) irq_in = 1'b1;
      end
      if (!rst && (bus_rd_en || bus_wr_en)) bus_activity++;
      if (bus_rd_en) begin
        rd_addr_q = bus_rd_addr;
        rd_cnt    = rd_lat;
        if (bus_rd_addr >= BASE && bus_rd_addr < 32'h1000 && bus_rd_addr[3:0] == 4'hC)
          reserved_reads++;
      end
      if (bus_wr_en) begin
        logic [63:0] e;
        chk("R4 byte enables", {28'd0, bus_wr_be}, 32'hF);
        if (wr_q.size() == 0) begin
          chk("R4 unexpected write addr", bus_wr_addr, 32'hFFFF_FFFF);
        end else begin
          e = wr_q.pop_front();
          chk("R4 write addr", bus_wr_addr, e[63:32]);
          chk("R4 write data", bus_wr_data, e[31:0]);
        end
        if (bus_wr_addr[31:28] == 4'h8) dev_regs[bus_wr_addr[5:2]] = bus_wr_data;
        if (bus_wr_addr == REG_BELL) irq_cnt = irq_delay;
        if (bus_wr_addr == REG_ACK) irq_in = 1'b0;
      end
    end
  end

  // Scoreboard monitor for operation events.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && ev_valid) begin
        logic [10:0] e;
        if (ev_q.size() == 0) begin
          chk("R9 unexpected event pc", {24'd0, ev_pc}, 32'hFF);
        end else begin
          e = ev_q.pop_front();
          chk("R9 event pc", {24'd0, ev_pc}, {24'd0, e[10:3]});
          chk("R9 event flags", {29'd0, ev_flags}, {29'd0, e[2:0]});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = '0;
    for (int i = 0; i < 16; i++) dev_regs[i] = '0;
    rst = 1'b1; start = 1'b0; irq_in = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pc", {24'd0, pc}, 0);
    chk("R1 reset halted", {31'd0, halted}, 0);
    repeat (20) @(negedge clk);
    chk("R1 no bus activity before start", bus_activity, 0);

    // Script A: write, doorbell, wait, read back, ack, stop.
    put_rec(0, 1, REG_DATA, 32'h0000_00A5);
    put_rec(1, 1, REG_BELL, 1);
    put_rec(2, 3, 0, 0);
    put_rec(3, 2, REG_DATA, 0);
    put_rec(4, 1, REG_ACK, 1);
    put_rec(5, 0, 0, 0);
    exp_wr(REG_DATA, 32'hA5); exp_wr(REG_BELL, 1); exp_wr(REG_ACK, 1);
    exp_ev(0, 3'b001); exp_ev(1, 3'b001); exp_ev(2, 3'b010);
    exp_ev(3, 3'b001); exp_ev(4, 3'b001); exp_ev(5, 3'b100);
    rd_lat = 3; irq_delay = 150;
    pulse_start();
    while (pc != 8'd2) @(negedge clk);
    repeat (40) @(negedge clk);
    chk("R6 pc held in wait", {24'd0, pc}, 2);
    chk("R6 not halted in wait", {31'd0, halted}, 0);
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R8 start while running ignored", {24'd0, pc}, 2);
    while (!halted) @(negedge clk);
    chk("R7 halted after stop", {31'd0, halted}, 1);
    chk("R10 pc at stop record", {24'd0, pc}, 5);
    chk("R5 read value", read_value, 32'hA5);
    repeat (20) @(negedge clk);
    chk("R7 pc holds while stopped", {24'd0, pc}, 5);
    chk("R7 halted sticky", {31'd0, halted}, 1);
    chk("R9 script A events drained", ev_q.size(), 0);

    // Script B: wait with interrupt already high, then an unknown opcode.
    put_rec(0, 3, 0, 0);
    put_rec(1, 7, REG_SPARE, 32'h1111_1111);
    put_rec(2, 1, REG_SPARE, 32'h2222_2222);
    exp_ev(0, 3'b010); exp_ev(1, 3'b100);
    rd_lat = 1;
    irq_in = 1'b1;
    pulse_start();
    chk("R7 restart clears halted", {31'd0, halted}, 0);
    while (!halted) @(negedge clk);
    irq_in = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 unknown opcode stops at record 1", {24'd0, pc}, 1);
    chk("R3 no write after unknown opcode", dev_regs[3], 0);
    chk("R9 script B events drained", ev_q.size(), 0);

    // Script C: read under long latency.
    dev_regs[3] = 32'h1234_5678;
    put_rec(0, 2, REG_SPARE, 0);
    put_rec(1, 0, 0, 0);
    exp_ev(0, 3'b001); exp_ev(1, 3'b100);
    rd_lat = 9;
    pulse_start();
    while (!halted) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R5 slow read value", read_value, 32'h1234_5678);
    chk("R10 pc after read and stop", {24'd0, pc}, 1);
    chk("R9 script C events drained", ev_q.size(), 0);
    chk("R4 all writes seen", wr_q.size(), 0);
    chk("R2 reserved word never fetched", reserved_reads, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule